// File: doc/BRIEF.md
# Pulse-Synchronous Range-Gate Sample Selector

This block sits in a received complex-sample stream and keeps only a range gate of samples tied to each transmitted pulse. For each pulse it forwards a configured count of consecutive samples, beginning a configured offset after the pulse start, and drops all other samples. The pulse start comes from one of two sources. In free-running mode an internal counter of accepted samples marks a new pulse every period samples. In trigger mode a marker bit, carried with the transmit stream, marks a new pulse on each rising edge. Neither mode needs a command from the host for each pulse, so pulse rates in the kilohertz range run unattended.

Each range gate leaves the block as one packet that closes with `m_last_o`. Every beat carries the timestamp of the packet's first sample. The block rebuilds that timestamp from the last stamp seen on the input, advanced by one for each sample since, so a stamp that lands on a dropped sample is not lost. A kept sample is held back until the next input sample is accepted. This lets the block mark a packet's last beat correctly when a new pulse cuts a gate short.

Top module: `range_gate_sel`

## Requirements
- R1: After pulse start sample index 0, the samples with indices OFFSET to OFFSET+COUNT-1 are forwarded in order and all other samples are dropped. A kept sample appears on the output once the next input sample has been accepted.
- R2: OFFSET, COUNT and PERIOD are sampled at a pulse-start sample, and the sampled values govern that whole pulse. A change between pulse starts has no effect until the next pulse start.
- R3: With `free_run_i`=1 the first sample accepted after reset is a pulse start, and so is every PERIOD-th accepted sample after it. PERIOD 0 or 1 makes every sample a pulse start.
- R4: With `free_run_i`=0 an accepted sample is a pulse start when its `tx_marker_i` is 1 and the previously accepted sample's marker was 0. The marker counts as 0 after reset.
- R5: A sample's time is `s_time_i` when `s_time_vld_i`=1, and otherwise the previous sample's time plus one, starting from 0 after reset. Every beat of a packet carries on `m_time_o` the time of that packet's first sample.
- R6: `m_last_o` is 1 on the COUNT-th kept sample of a gate, so each complete gate forms exactly one packet.
- R7: While `m_valid_o`=1 and `m_ready_i`=0, the output beat holds stable and no input is accepted. Back-pressure never drops a sample inside a gate.
- R8: If a pulse start arrives before a gate completes, the last kept sample before it carries `m_last_o`=1 and the offset count restarts from the new pulse.
- R9: COUNT=0 produces no output beats.
- R10: After reset `m_valid_o`=0 and `s_ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| free_run_i | input | 1 | 1: internal period counter, 0: transmit marker |
| cfg_offset_i | input | CNT_W | Samples skipped after pulse start |
| cfg_count_i | input | CNT_W | Samples kept per pulse |
| cfg_period_i | input | CNT_W | Free-running pulse period in samples |
| tx_marker_i | input | 1 | Transmit marker bit, sampled with each input sample |
| s_data_i | input | DATA_W | Input IQ sample |
| s_time_i | input | TIME_W | Input timestamp |
| s_time_vld_i | input | 1 | Timestamp attached to this sample |
| s_valid_i | input | 1 | Input sample valid |
| s_ready_o | output | 1 | Input sample accepted |
| m_data_o | output | DATA_W | Output IQ sample |
| m_time_o | output | TIME_W | Timestamp of the packet's first sample |
| m_last_o | output | 1 | Last beat of the packet |
| m_valid_o | output | 1 | Output beat valid |
| m_ready_i | input | 1 | Downstream ready |

## Verification
The bench builds the block with its default parameters: 32-bit samples, 64-bit time and 32-bit counters. Offsets, counts and periods stay small, so each run covers many pulses and gates. These settings reach a period of 1, an offset of 0, a COUNT of 0, a count change in the middle of a gate, and trigger edges that arrive before a gate completes. Timestamps reach the block only on every seventh sample, so most packet starts fall on an unstamped sample.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SKIP,
    ST_KEEP,
    ST_DONE
  } gate_st_e;
endpackage

// File: rtl/rg_pulse_src.sv
module rg_pulse_src #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             free_run_i,
  input  logic             marker_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             pulse_o
);
  logic [CNT_W-1:0] phase_q, per_q, per_eff, phase_inc;
  logic             mark_q;

  assign pulse_o   = free_run_i ? (phase_q == '0) : (marker_i && !mark_q);
  assign per_eff   = (phase_q == '0) ? period_i : per_q;
  assign phase_inc = phase_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      per_q   <= '0;
      mark_q  <= 1'b0;
    end else if (acc_i) begin
      mark_q <= marker_i;
      if (phase_q == '0) per_q <= period_i;
      // period is latched at the wrap, so a new value waits for the next pulse
      if (phase_inc >= per_eff || phase_inc == '0) phase_q <= '0;
      else                                         phase_q <= phase_inc;
    end
  end
endmodule

// File: rtl/rg_gate_fsm.sv
module rg_gate_fsm
  import rg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             pulse_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             keep_o,
  output logic             last_o,
  output logic             first_o
);
  gate_st_e         st_q, st_e, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_e, cnt_n, num_q, num_e;

  always_comb begin
    st_e    = pulse_i ? ST_SKIP  : st_q;
    cnt_e   = pulse_i ? offset_i : cnt_q;
    num_e   = pulse_i ? count_i  : num_q;
    st_n    = st_e;
    cnt_n   = cnt_e;
    keep_o  = 1'b0;
    last_o  = 1'b0;
    first_o = 1'b0;
    case (st_e)
      ST_SKIP: begin
        if (num_e == '0) begin
          st_n = ST_DONE;
        end else if (cnt_e == '0) begin
          keep_o  = 1'b1;
          first_o = 1'b1;
          if (num_e == CNT_W'(1)) begin
            last_o = 1'b1;
            st_n   = ST_DONE;
          end else begin
            st_n  = ST_KEEP;
            cnt_n = CNT_W'(1);
          end
        end else begin
          cnt_n = cnt_e - 1'b1;
        end
      end
      ST_KEEP: begin
        keep_o = 1'b1;
        if (cnt_e + 1'b1 == num_e) begin
          last_o = 1'b1;
          st_n   = ST_DONE;
        end else begin
          cnt_n = cnt_e + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      num_q <= '0;
    end else if (acc_i) begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      num_q <= num_e;
    end
  end
endmodule

// File: rtl/rg_stamp.sv
module rg_stamp #(
  parameter int TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              time_vld_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              first_i,
  output logic [TIME_W-1:0] pkt_time_o
);
  logic [TIME_W-1:0] next_q, pkt_q, cur_t;

  // time of the sample on the input now: its own stamp or the extrapolation
  assign cur_t      = time_vld_i ? time_i : next_q;
  assign pkt_time_o = first_i ? cur_t : pkt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= '0;
      pkt_q  <= '0;
    end else if (acc_i) begin
      next_q <= cur_t + 1'b1;
      if (first_i) pkt_q <= cur_t;
    end
  end
endmodule

// File: rtl/range_gate_sel.sv
module range_gate_sel #(
  parameter int DATA_W = 32,
  parameter int TIME_W = 64,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              free_run_i,
  input  logic [CNT_W-1:0]  cfg_offset_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic [CNT_W-1:0]  cfg_period_i,
  input  logic              tx_marker_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic [TIME_W-1:0] s_time_i,
  input  logic              s_time_vld_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic [TIME_W-1:0] m_time_o,
  output logic              m_last_o,
  output logic              m_valid_o,
  input  logic              m_ready_i
);
  logic              acc, pulse, keep, last, first;
  logic [TIME_W-1:0] pkt_time;
  logic              pend_v_q, pend_l_q;
  logic [DATA_W-1:0] pend_d_q;
  logic [TIME_W-1:0] pend_t_q;

  assign s_ready_o = !m_valid_o || m_ready_i;
  assign acc       = s_valid_i && s_ready_o;

  rg_pulse_src #(.CNT_W(CNT_W)) i_pulse (
    .clk_i, .rst_ni, .acc_i(acc), .free_run_i,
    .marker_i(tx_marker_i), .period_i(cfg_period_i), .pulse_o(pulse)
  );

  rg_gate_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk_i, .rst_ni, .acc_i(acc), .pulse_i(pulse),
    .offset_i(cfg_offset_i), .count_i(cfg_count_i),
    .keep_o(keep), .last_o(last), .first_o(first)
  );

  rg_stamp #(.TIME_W(TIME_W)) i_stamp (
    .clk_i, .rst_ni, .acc_i(acc), .time_vld_i(s_time_vld_i),
    .time_i(s_time_i), .first_i(first), .pkt_time_o(pkt_time)
  );

  // one kept sample is held back until the next input decides its last flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q  <= 1'b0;
      pend_l_q  <= 1'b0;
      pend_d_q  <= '0;
      pend_t_q  <= '0;
      m_valid_o <= 1'b0;
      m_last_o  <= 1'b0;
      m_data_o  <= '0;
      m_time_o  <= '0;
    end else begin
      if (m_ready_i) m_valid_o <= 1'b0;
      if (acc) begin
        if (pend_v_q) begin
          m_valid_o <= 1'b1;
          m_data_o  <= pend_d_q;
          m_time_o  <= pend_t_q;
          m_last_o  <= pend_l_q || pulse;
        end
        pend_v_q <= keep;
        if (keep) begin
          pend_d_q <= s_data_i;
          pend_l_q <= last;
          pend_t_q <= pkt_time;
        end
      end
    end
  end
endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
  parameter int DATA_W = 32,
  parameter int TIME_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_valid_i,
  input logic              s_ready_o,
  input logic [DATA_W-1:0] m_data_o,
  input logic [TIME_W-1:0] m_time_o,
  input logic              m_last_o,
  input logic              m_valid_o,
  input logic              m_ready_i
);
  logic              in_pkt_q;
  logic [TIME_W-1:0] pkt_t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q <= 1'b0;
      pkt_t_q  <= '0;
    end else if (m_valid_o && m_ready_i) begin
      in_pkt_q <= !m_last_o;
      pkt_t_q  <= m_time_o;
    end
  end

  a_r7_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_last_o) && $stable(m_time_o));

  a_r1_quiet_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_valid_i && (!m_valid_o || m_ready_i) |=> !m_valid_o);

  a_r1_beat_from_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_valid_o) |-> $past(s_valid_i && s_ready_o));

  a_r5_packet_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pkt_q && m_valid_o |-> m_time_o == pkt_t_q);
endmodule

bind range_gate_sel rg_checker #(.DATA_W(DATA_W), .TIME_W(TIME_W)) i_rg_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
  .m_data_o(m_data_o), .m_time_o(m_time_o), .m_last_o(m_last_o),
  .m_valid_o(m_valid_o), .m_ready_i(m_ready_i)
);

// File: tb/test_range_gate_sel.sv
module test_range_gate_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NROW = 8;
  localparam int DATA_W = 32;
  localparam int TIME_W = 64;
  localparam int CNT_W  = 32;

  // rows: mode(1=free run), offset, count, period, trigger spacing, samples,
  // change index (-1 none), count after change, back-pressure
  localparam int T_FREE[NROW] = '{1, 1, 0, 0, 1, 1, 1, 0};
  localparam int T_OFF [NROW] = '{3, 0, 2, 1, 0, 3, 0, 0};
  localparam int T_NUM [NROW] = '{4, 3, 3, 10, 0, 5, 1, 2};
  localparam int T_PER [NROW] = '{10, 8, 1000, 1000, 5, 20, 1, 1000};
  localparam int T_TPER[NROW] = '{0, 0, 9, 6, 0, 0, 0, 4};
  localparam int T_NS  [NROW] = '{41, 33, 40, 31, 20, 41, 10, 30};
  localparam int T_CHG [NROW] = '{-1, -1, -1, -1, -1, 5, -1, -1};
  localparam int T_CNUM[NROW] = '{0, 0, 0, 0, 0, 2, 0, 0};
  localparam int T_STL [NROW] = '{0, 1, 1, 0, 0, 1, 0, 1};

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              free_run_i = 1'b0;
  logic [CNT_W-1:0]  cfg_offset_i = '0, cfg_count_i = '0, cfg_period_i = '0;
  logic              tx_marker_i = 1'b0;
  logic [DATA_W-1:0] s_data_i = '0;
  logic [TIME_W-1:0] s_time_i = '0;
  logic              s_time_vld_i = 1'b0;
  logic              s_valid_i = 1'b0;
  logic              s_ready_o;
  logic [DATA_W-1:0] m_data_o;
  logic [TIME_W-1:0] m_time_o;
  logic              m_last_o, m_valid_o;
  logic              m_ready_i = 1'b1;

  int n_chk = 0, n_fail = 0;
  bit stall_en = 1'b0, collect = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  longint got_d[$], got_l[$], got_t[$];
  longint exp_d[$], exp_l[$], exp_t[$];

  range_gate_sel #(.DATA_W(DATA_W), .TIME_W(TIME_W), .CNT_W(CNT_W)) i_range_gate_sel (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(negedge clk_i) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_ready_i = stall_en ? lfsr[0] : 1'b1;
    if (collect && m_valid_o && m_ready_i) begin
      got_d.push_back(longint'(m_data_o));
      got_l.push_back(longint'(m_last_o));
      got_t.push_back(longint'(m_time_o));
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    s_valid_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(m_valid_o == 1'b0, "R10", "m_valid after reset", longint'(m_valid_o), 0);
    chk(s_ready_o == 1'b1, "R10", "s_ready after reset", longint'(s_ready_o), 1);
  endtask

  function automatic bit mark_at(int r, int i);
    return (T_TPER[r] > 0) && ((i % T_TPER[r]) < 2);
  endfunction

  function automatic bit pulse_at(int r, int i);
    if (T_FREE[r] != 0) return (T_PER[r] <= 1) || ((i % T_PER[r]) == 0);
    return mark_at(r, i) && !(i > 0 && mark_at(r, i - 1));
  endfunction

  // reference: R1 window, R2 latch at pulse, R6/R8 last, R9 empty, R5 time
  task automatic build_expect(int r);
    int start = -1, loff = 0, lnum = 0, first = 0;
    exp_d.delete(); exp_l.delete(); exp_t.delete();
    for (int i = 0; i < T_NS[r] - 1; i++) begin
      if (pulse_at(r, i)) begin
        start = i;
        loff  = T_OFF[r];
        lnum  = (T_CHG[r] >= 0 && i >= T_CHG[r]) ? T_CNUM[r] : T_NUM[r];
      end
      if (start >= 0 && lnum > 0 && i - start >= loff && i - start < loff + lnum) begin
        if (i - start == loff) first = i;
        exp_d.push_back(longint'(i));
        exp_l.push_back(longint'((i - start == loff + lnum - 1) || pulse_at(r, i + 1)));
        exp_t.push_back(longint'(1000 + first));
      end
    end
  endtask

  task automatic run_row(int r);
    bit acc;
    do_reset();
    got_d.delete(); got_l.delete(); got_t.delete();
    free_run_i   = (T_FREE[r] != 0);
    cfg_offset_i = CNT_W'(T_OFF[r]);
    cfg_count_i  = CNT_W'(T_NUM[r]);
    cfg_period_i = CNT_W'(T_PER[r]);
    stall_en = (T_STL[r] != 0);
    collect  = 1'b1;
    for (int i = 0; i < T_NS[r]; i++) begin
      if (T_CHG[r] >= 0 && i == T_CHG[r]) cfg_count_i = CNT_W'(T_CNUM[r]);
      s_data_i     = DATA_W'(i);
      tx_marker_i  = mark_at(r, i);
      s_time_vld_i = (i % 7 == 0);
      s_time_i     = s_time_vld_i ? TIME_W'(1000 + i) : TIME_W'(64'hdead);
      s_valid_i    = 1'b1;
      acc = 1'b0;
      while (!acc) begin
        acc = s_ready_o;
        @(posedge clk_i);
        @(negedge clk_i);
        #1;
      end
    end
    s_valid_i = 1'b0;
    stall_en  = 1'b0;
    repeat (8) @(negedge clk_i);
    collect = 1'b0;
    build_expect(r);
    chk(got_d.size() == exp_d.size(), (T_NUM[r] == 0) ? "R9" : "R1",
        $sformatf("row %0d beat count", r), longint'(got_d.size()), longint'(exp_d.size()));
    for (int k = 0; k < got_d.size() && k < exp_d.size(); k++) begin
      chk(got_d[k] == exp_d[k], (T_CHG[r] >= 0) ? "R2" : (T_FREE[r] != 0 ? "R3" : "R4"),
          $sformatf("row %0d beat %0d data", r, k), got_d[k], exp_d[k]);
      chk(got_l[k] == exp_l[k], (T_TPER[r] == 6) ? "R8" : "R6",
          $sformatf("row %0d beat %0d last", r, k), got_l[k], exp_l[k]);
      chk(got_t[k] == exp_t[k], "R5",
          $sformatf("row %0d beat %0d time", r, k), got_t[k], exp_t[k]);
    end
  endtask

  // R7: a stalled beat holds and blocks the input
  task automatic stall_check();
    do_reset();
    free_run_i = 1'b1; cfg_offset_i = '0; cfg_count_i = 32'd4; cfg_period_i = 32'd100;
    stall_en = 1'b0;
    collect = 1'b0;
    s_time_vld_i = 1'b1;
    for (int i = 0; i < 2; i++) begin
      s_data_i = DATA_W'(50 + i);
      s_time_i = TIME_W'(7000 + i);
      s_valid_i = 1'b1;
      @(posedge clk_i);
      @(negedge clk_i);
    end
    s_valid_i = 1'b0;
    force m_ready_i = 1'b0;
    #1;
    chk(m_valid_o == 1'b1 && m_data_o == 50, "R7", "beat presented", longint'(m_data_o), 50);
    s_data_i = DATA_W'(52);
    s_valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    #1;
    chk(s_ready_o == 1'b0, "R7", "input blocked on stall", longint'(s_ready_o), 0);
    chk(m_data_o == 50 && m_valid_o, "R7", "beat held on stall", longint'(m_data_o), 50);
    chk(m_time_o == 7000, "R7", "time held on stall", longint'(m_time_o), 7000);
    release m_ready_i;
    s_valid_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int r = 0; r < NROW; r++) run_row(r);
    stall_check();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule